// File: doc/BRIEF.md
# Dual-Port Flash Bank Arbiter

This block stands between two system bus request ports and three flash banks. On every cycle it decides, without any added register stage, which port reaches which bank. Each port presents a valid flag, an address, a read/write flag and a 3-bit master number. Two address bits pick the bank. A request whose bank code is unmapped, or whose master lacks the needed permission, gets an error response in the same cycle. Such a request never reaches a bank and plays no part in arbitration. A legal request is either granted in the same cycle or held by the port until it is granted.

Contention is resolved only when both legal requests name the same bank. Requests to different banks are granted together. A 32-bit configuration word selects the contention policy: port 0 always wins, port 1 always wins, or the two alternate. The same word holds a 2-bit read/write permission for each of eight masters and a prefetch-disable bit for each master. The word is loaded from a nonvolatile input while reset is high. A bus write can override it until the next reset.

Top module: `flash_bank_arb`

## Requirements
- R1: The bank code is `addr[BANK_LSB+1:BANK_LSB]`. Codes 0, 1 and 2 select banks 0, 1 and 2. Code 3 raises `p_err` for that port, with no grant.
- R2: Master m's permission field is `cfg[2m+1:2m]`. 00 allows nothing, 01 reads only, 10 writes only, 11 both. A request whose direction is not allowed raises `p_err` in the same cycle, never `p_gnt`.
- R3: Two legal requests to different banks are both granted in the same cycle.
- R4: With mode `cfg[25:24]` = 00, port 0 wins a same-bank contention.
- R5: With mode 01, port 1 wins a same-bank contention.
- R6: With mode 10 or 11, same-bank contentions alternate winners. The first contention after reset goes to port 0. Contentions that happen in fixed modes do not move the alternation.
- R7: A losing port gets no grant. It is granted in the first cycle its bank is no longer claimed by the other port.
- R8: For a granted port, its bank shows `bank_vld`=1, `bank_src` equal to the port number (0 or 1), and that port's address and write flag.
- R9: `p_pf_ok` is high exactly when the port is granted and master m's prefetch-disable bit `cfg[16+m]` is 0.
- R10: Configuration layout: `cfg[31:26]` always reads 0, `[25:24]` is the mode, `[23:16]` holds the prefetch-disable bits, and `[15:0]` holds the permission fields.
- R11: While `rst` is high the register takes `nv_cfg_word` with bits 31:26 cleared. An erased word (all ones) gives `32'h03FF_FFFF`.
- R12: A `cfg_we` pulse changes `cfg_rdata` and the active settings from the next cycle. The next reset restores the nonvolatile value.
- R13: A refused request does not contend. If the other port asks for the same bank, that port is granted in any mode, and the alternation does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads the configuration |
| nv_cfg_word | input | 32 | Nonvolatile configuration value sampled during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Active configuration word |
| p_vld | input | 2 | Request valid, one per port |
| p_addr | input | 2 x ADDR_W | Request address per port |
| p_wr | input | 2 | 1 = write, 0 = read, per port |
| p_mst | input | 2 x 3 | Master number per port |
| p_gnt | output | 2 | Grant per port |
| p_err | output | 2 | Error response per port |
| p_pf_ok | output | 2 | Prefetch may be triggered by this granted access |
| bank_vld | output | 3 | Bank is driven this cycle |
| bank_addr | output | 3 x ADDR_W | Address driven to each bank |
| bank_wr | output | 3 | Write flag driven to each bank |
| bank_src | output | 3 | Port that owns each bank |

## Verification
The permission check and same-bank arbitration can act in the same cycle. The bench provokes this by having both ports name one bank while one master is refused, under both fixed policies and under alternation. It judges the result by the surviving port's grant, the refused port's error, and the next genuine contention. That contention must still go to the port the alternation owed, which shows the refused request left the policy state untouched.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  localparam int NUM_PORTS = 2;
  localparam int NUM_BANKS = 3;
  localparam int NUM_MST   = 8;
  localparam int CFG_W     = 32;
  localparam logic [CFG_W-1:0] CFG_LIVE_MASK = 32'h03FF_FFFF;

  typedef enum logic [1:0] {
    ARB_FIX_P0 = 2'b00,
    ARB_FIX_P1 = 2'b01,
    ARB_ALT_A  = 2'b10,
    ARB_ALT_B  = 2'b11
  } arb_mode_e;

  function automatic logic [1:0] perm_of(input logic [2*NUM_MST-1:0] acc,
                                         input logic [2:0] mst);
    return acc[2*mst +: 2];
  endfunction

  function automatic logic perm_allows(input logic [1:0] field, input logic wr);
    return wr ? field[1] : field[0];
  endfunction

  function automatic logic bank_mapped(input logic [1:0] code);
    return code != 2'd3;
  endfunction
endpackage

// File: rtl/flash_arb_cfg.sv
module flash_arb_cfg
  import flash_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_W-1:0]     nv_word,
  input  logic                 we,
  input  logic [CFG_W-1:0]     wdata,
  output logic [CFG_W-1:0]     cfg_q,
  output arb_mode_e            mode,
  output logic [NUM_MST-1:0]   pf_dis,
  output logic [2*NUM_MST-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= nv_word & CFG_LIVE_MASK;
    else if (we) cfg_q <= wdata & CFG_LIVE_MASK;
  end

  assign mode   = arb_mode_e'(cfg_q[25:24]);
  assign pf_dis = cfg_q[23:16];
  assign acc    = cfg_q[15:0];
endmodule

// File: rtl/flash_arb_req_chk.sv
module flash_arb_req_chk
  import flash_arb_pkg::*;
(
  input  logic                 vld,
  input  logic [1:0]           bank_code,
  input  logic                 wr,
  input  logic [2:0]           mst,
  input  logic [2*NUM_MST-1:0] acc,
  output logic                 legal,
  output logic                 err
);
  logic perm_ok;
  assign perm_ok = perm_allows(perm_of(acc, mst), wr);
  assign legal   = vld & bank_mapped(bank_code) & perm_ok;
  assign err     = vld & ~legal;
endmodule

// File: rtl/flash_arb_core.sv
module flash_arb_core
  import flash_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] legal,
  input  logic [1:0]           code0,
  input  logic [1:0]           code1,
  input  arb_mode_e            mode,
  output logic [NUM_PORTS-1:0] gnt,
  output logic                 conflict,
  output logic                 alt_fav
);
  logic win1;

  assign conflict = legal[0] & legal[1] & (code0 == code1);

  always_comb begin
    unique case (mode)
      ARB_FIX_P0: win1 = 1'b0;
      ARB_FIX_P1: win1 = 1'b1;
      default:    win1 = alt_fav;
    endcase
  end

  assign gnt[0] = legal[0] & ~(conflict & win1);
  assign gnt[1] = legal[1] & ~(conflict & ~win1);

  always_ff @(posedge clk) begin
    if (rst)                      alt_fav <= 1'b0;
    else if (conflict && mode[1]) alt_fav <= ~alt_fav;
  end
endmodule

// File: rtl/flash_bank_arb.sv
module flash_bank_arb
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BANK_LSB = 18
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [31:0]                       nv_cfg_word,
  input  logic                              cfg_we,
  input  logic [31:0]                       cfg_wdata,
  output logic [31:0]                       cfg_rdata,
  input  logic [1:0]                        p_vld,
  input  logic [1:0][ADDR_W-1:0]            p_addr,
  input  logic [1:0]                        p_wr,
  input  logic [1:0][2:0]                   p_mst,
  output logic [1:0]                        p_gnt,
  output logic [1:0]                        p_err,
  output logic [1:0]                        p_pf_ok,
  output logic [2:0]                        bank_vld,
  output logic [2:0][ADDR_W-1:0]            bank_addr,
  output logic [2:0]                        bank_wr,
  output logic [2:0]                        bank_src
);
  arb_mode_e                   mode;
  logic [NUM_MST-1:0]          pf_dis;
  logic [2*NUM_MST-1:0]        acc;
  logic [NUM_PORTS-1:0][1:0]   code;
  logic [NUM_PORTS-1:0]        p_legal;
  logic                        conflict;
  logic                        alt_fav;

  flash_arb_cfg cfg_i (
    .clk(clk), .rst(rst), .nv_word(nv_cfg_word), .we(cfg_we), .wdata(cfg_wdata),
    .cfg_q(cfg_rdata), .mode(mode), .pf_dis(pf_dis), .acc(acc)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign code[p] = p_addr[p][BANK_LSB+1:BANK_LSB];
    flash_arb_req_chk chk_i (
      .vld(p_vld[p]), .bank_code(code[p]), .wr(p_wr[p]), .mst(p_mst[p]),
      .acc(acc), .legal(p_legal[p]), .err(p_err[p])
    );
    assign p_pf_ok[p] = p_gnt[p] & ~pf_dis[p_mst[p]];
  end

  flash_arb_core core_i (
    .clk(clk), .rst(rst), .legal(p_legal), .code0(code[0]), .code1(code[1]),
    .mode(mode), .gnt(p_gnt), .conflict(conflict), .alt_fav(alt_fav)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_PORTS-1:0] own;
    assign own[0]       = p_gnt[0] & (code[0] == 2'(b));
    assign own[1]       = p_gnt[1] & (code[1] == 2'(b));
    assign bank_vld[b]  = |own;
    assign bank_src[b]  = own[1];
    assign bank_addr[b] = own[1] ? p_addr[1] : p_addr[0];
    assign bank_wr[b]   = own[1] ? p_wr[1] : (own[0] & p_wr[0]);
  end
endmodule

// File: rtl/flash_arb_checks.sv
module flash_arb_checks #(
  parameter int ADDR_W   = 20,
  parameter int BANK_LSB = 18
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_we,
  input logic [31:0]            cfg_wdata,
  input logic [31:0]            cfg_rdata,
  input logic [1:0]             p_vld,
  input logic [1:0][ADDR_W-1:0] p_addr,
  input logic [1:0]             p_gnt,
  input logic [1:0]             p_err,
  input logic [1:0]             p_legal,
  input logic                   conflict,
  input logic [1:0]             mode
);
  logic have_last, last_w;
  logic [1:0] alt_exp;
  logic alt_conf;

  assign alt_conf = conflict & mode[1];
  assign alt_exp  = !have_last ? 2'b01 : (last_w ? 2'b01 : 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_last <= 1'b0;
      last_w    <= 1'b0;
    end else if (alt_conf) begin
      have_last <= 1'b1;
      last_w    <= p_gnt[1];
    end
  end

  // R2
  gnt_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (p_gnt & p_err) == 2'b00);
  // R1
  unmapped0_err_chk: assert property (@(posedge clk) disable iff (rst)
    (p_vld[0] && p_addr[0][BANK_LSB+1:BANK_LSB] == 2'd3) |-> p_err[0]);
  // R1
  unmapped1_err_chk: assert property (@(posedge clk) disable iff (rst)
    (p_vld[1] && p_addr[1][BANK_LSB+1:BANK_LSB] == 2'd3) |-> p_err[1]);
  // R3
  concurrent_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (&p_legal && !conflict) |-> p_gnt == 2'b11);
  // R4
  fixed_p0_chk: assert property (@(posedge clk) disable iff (rst)
    (conflict && mode == 2'b00) |-> p_gnt == 2'b01);
  // R5
  fixed_p1_chk: assert property (@(posedge clk) disable iff (rst)
    (conflict && mode == 2'b01) |-> p_gnt == 2'b10);
  // R6
  alt_order_chk: assert property (@(posedge clk) disable iff (rst)
    alt_conf |-> p_gnt == alt_exp);
  // R10
  cfg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[31:26] == 6'b0);
  // R12
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 32'h03FF_FFFF));
endmodule

bind flash_bank_arb flash_arb_checks #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .p_vld(p_vld), .p_addr(p_addr), .p_gnt(p_gnt), .p_err(p_err), .p_legal(p_legal),
  .conflict(conflict), .mode(mode)
);

// File: tb/flash_bank_arb_tb.sv
module flash_bank_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int BANK_LSB   = 18;
  localparam logic [7:0]  PFD = 8'h0A;   // masters 1 and 3 may not prefetch
  localparam logic [15:0] ACC = 16'hE4FF; // m7=11 m6=10 m5=01 m4=00 m3..m0=11

  typedef struct packed {
    logic [1:0] mode;
    logic v0; logic [1:0] b0; logic w0; logic [2:0] m0;
    logic v1; logic [1:0] b1; logic w1; logic [2:0] m1;
    logic [1:0] eg; logic [1:0] ee;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1,2'd0,1'b0,3'd0, 1'b1,2'd1,1'b0,3'd1, 2'b11,2'b00},
    '{2'b00, 1'b1,2'd2,1'b1,3'd0, 1'b1,2'd2,1'b0,3'd2, 2'b01,2'b00},
    '{2'b01, 1'b1,2'd2,1'b1,3'd0, 1'b1,2'd2,1'b0,3'd2, 2'b10,2'b00},
    '{2'b00, 1'b1,2'd3,1'b0,3'd0, 1'b0,2'd0,1'b0,3'd0, 2'b00,2'b01},
    '{2'b00, 1'b1,2'd1,1'b0,3'd4, 1'b0,2'd0,1'b0,3'd0, 2'b00,2'b01},
    '{2'b00, 1'b0,2'd0,1'b0,3'd0, 1'b1,2'd1,1'b1,3'd4, 2'b00,2'b10},
    '{2'b00, 1'b1,2'd1,1'b1,3'd5, 1'b0,2'd0,1'b0,3'd0, 2'b00,2'b01},
    '{2'b00, 1'b1,2'd1,1'b0,3'd5, 1'b0,2'd0,1'b0,3'd0, 2'b01,2'b00},
    '{2'b00, 1'b0,2'd0,1'b0,3'd0, 1'b1,2'd0,1'b0,3'd6, 2'b00,2'b10},
    '{2'b00, 1'b1,2'd0,1'b1,3'd6, 1'b0,2'd0,1'b0,3'd0, 2'b01,2'b00},
    '{2'b00, 1'b1,2'd1,1'b0,3'd4, 1'b1,2'd1,1'b0,3'd0, 2'b10,2'b01},
    '{2'b01, 1'b1,2'd0,1'b0,3'd7, 1'b1,2'd3,1'b1,3'd3, 2'b01,2'b10},
    '{2'b01, 1'b1,2'd2,1'b1,3'd7, 1'b1,2'd2,1'b1,3'd4, 2'b01,2'b10},
    '{2'b00, 1'b1,2'd1,1'b1,3'd7, 1'b1,2'd0,1'b1,3'd3, 2'b11,2'b00}
  };

  logic clk = 1'b0;
  logic rst;
  logic [31:0] nv_cfg_word, cfg_wdata, cfg_rdata;
  logic cfg_we;
  logic [1:0] p_vld, p_wr, p_gnt, p_err, p_pf_ok;
  logic [1:0][ADDR_W-1:0] p_addr;
  logic [1:0][2:0] p_mst;
  logic [2:0] bank_vld, bank_wr, bank_src;
  logic [2:0][ADDR_W-1:0] bank_addr;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bank_arb #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)) dut_i (.*);

  function automatic string vec_tag(input int i);
    case (i)
      0, 13:       return "R3";
      1:           return "R4";
      2:           return "R5";
      3, 11:       return "R1";
      10, 12:      return "R13";
      default:     return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    p_vld = '0; p_wr = '0; p_addr = '0; p_mst = '0;
  endtask

  task automatic drive(input int p, input logic [1:0] b, input logic w, input logic [2:0] m,
                       input logic [17:0] off);
    p_vld[p] = 1'b1; p_wr[p] = w; p_mst[p] = m; p_addr[p] = {b, off};
  endtask

  task automatic do_reset(input logic [31:0] nv);
    @(negedge clk);
    rst = 1'b1; nv_cfg_word = nv; cfg_we = 1'b0; idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    idle(); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL all watchdog got=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cfg_wdata = '0;
    // R11: erased word gives all defined fields at one
    do_reset(32'hFFFF_FFFF);
    #2;
    check("R11 erased", cfg_rdata, 32'h03FF_FFFF);
    check("R11 idle gnt", {30'b0, p_gnt}, 32'h0);

    // R6: alternation starts with port 0 after reset (erased mode = 11)
    @(negedge clk);
    drive(0, 2'd2, 1'b0, 3'd0, 18'h1); drive(1, 2'd2, 1'b0, 3'd1, 18'h2);
    #2; check("R6 first p0", {30'b0, p_gnt}, 32'h1);
    @(negedge clk); #2; check("R6 then p1", {30'b0, p_gnt}, 32'h2);
    @(negedge clk); #2; check("R6 then p0", {30'b0, p_gnt}, 32'h1);

    // R13: refused master does not contend nor move alternation (mode 10)
    write_cfg({6'b0, 2'b10, PFD, ACC});
    @(negedge clk);
    drive(0, 2'd0, 1'b0, 3'd4, 18'h3); drive(1, 2'd0, 1'b0, 3'd0, 18'h4);
    #2; check("R13 refused p0 gnt", {30'b0, p_gnt}, 32'h2);
    check("R13 refused p0 err", {30'b0, p_err}, 32'h1);
    @(negedge clk);
    drive(0, 2'd0, 1'b0, 3'd0, 18'h3);
    #2; check("R13 alternation kept p1", {30'b0, p_gnt}, 32'h2);
    @(negedge clk); #2; check("R6 back to p0", {30'b0, p_gnt}, 32'h1);

    // R7: loser granted once bank is free (mode 00)
    write_cfg({6'b0, 2'b00, PFD, ACC});
    @(negedge clk);
    drive(0, 2'd1, 1'b0, 3'd0, 18'h5); drive(1, 2'd1, 1'b1, 3'd2, 18'h6);
    #2; check("R7 loser waits", {30'b0, p_gnt}, 32'h1);
    @(negedge clk);
    p_vld[0] = 1'b0;
    #2; check("R7 loser granted", {30'b0, p_gnt}, 32'h2);
    check("R8 bank1 from p1", {29'b0, bank_src}, 32'h2);
    check("R8 bank1 addr", {12'b0, bank_addr[1]}, {12'b0, 2'd1, 18'h6});

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [1:0] epf;
      v = VECS[i];
      write_cfg({6'b0, v.mode, PFD, ACC});
      @(negedge clk);
      if (v.v0) drive(0, v.b0, v.w0, v.m0, 18'(i + 32'h100));
      if (v.v1) drive(1, v.b1, v.w1, v.m1, 18'(i + 32'h200));
      #2;
      check({vec_tag(i), " gnt"}, {30'b0, p_gnt}, {30'b0, v.eg});
      check({vec_tag(i), " err"}, {30'b0, p_err}, {30'b0, v.ee});
      epf[0] = v.eg[0] & ~PFD[v.m0];
      epf[1] = v.eg[1] & ~PFD[v.m1];
      check("R9 pf_ok", {30'b0, p_pf_ok}, {30'b0, epf});
      for (int p = 0; p < 2; p++) begin
        if (v.eg[p]) begin
          logic [1:0] b;
          b = (p == 0) ? v.b0 : v.b1;
          check("R8 bank drive",
                {8'b0, bank_vld[b], bank_src[b], bank_wr[b], 1'b0, bank_addr[b]},
                {8'b0, 1'b1, 1'(p), p_wr[p], 1'b0, p_addr[p]});
        end
      end
    end

    // R10/R12: write masks top bits, field move changes permission
    write_cfg(32'hFFFF_FFFC);
    #2; check("R12 write visible", cfg_rdata, 32'h03FF_FFFC);
    @(negedge clk);
    drive(0, 2'd0, 1'b0, 3'd0, 18'h7);
    #2; check("R10 m0 field at [1:0]", {30'b0, p_err}, 32'h1);
    // R12: reset reloads nonvolatile value
    do_reset(32'hFFAA_5501);
    #2; check("R12 reload", cfg_rdata, 32'h03AA_5501);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule